// File: doc/BRIEF.md
# Byte-Level I2C Master Register Sequencer

This block is the control core of a memory-mapped I2C master. A host reads and writes five 8-bit registers: control, status, data, own address and clock divider. Each data access is turned into a byte-level operation toward an I2C target: start with an address byte, send a byte, receive a byte, or stop. Bit timing on SCL and SDA is handled elsewhere. The divider is only stored and read back here. Target-side (slave) behaviour is not modelled.

With master mode selected and no transfer open, the first data write is taken as the address byte. Later data writes send payload bytes. Each data read returns the byte fetched by the previous read, and launches the fetch of the next byte. Some control writes close the open transfer and issue a stop: a soft reset, leaving master mode, or a repeated-start request. Each completed address, send or receive raises a pending flag. One interrupt line follows that flag, gated by the enable bits.

The target side uses one operation at a time. It is held on a valid/ready handshake, and the acknowledge and the received byte are sampled on the handshake cycle. The host port stalls through `host_ready` while an operation is outstanding.

Top module: `i2cbm_top`

## Requirements
- R1: After reset every register reads 0x00, the interrupt line is low, no target operation is pending and `host_ready` is high.
- R2: The interrupt line is high exactly when the pending flag (status bit 1) is set and both control bit 7 (module enable) and control bit 6 (interrupt enable) are set.
- R3: Writing control with bit 7 clear while bit 7 was set performs a soft reset. Control, status, divider and the received byte return to 0, the own-address register keeps its value, and an open transfer is closed with a stop operation (code 3).
- R4: A control write with bit 5 (master) set makes status bit 5 (bus busy) read 1. A control write with bit 5 clear makes bus busy read 0, and closes an open transfer with a stop operation.
- R5: A control write with bit 2 (repeated start) set while a transfer is open issues a stop, closes the transfer, and control bit 2 then reads 0. With no transfer open, bit 2 is stored and reads back 1.
- R6: Status bit 1 (pending) clears only when status is written with that bit 0 while it is 1. Writing it as 1 leaves it unchanged, and clearing it drops the interrupt line.
- R7: A data write (offset 0x4) issues no target operation while the module is disabled or master mode is clear.
- R8: In master mode with no transfer open, a data write issues a start operation (code 0) carrying the byte: bits 7:1 are the target address and bit 0 is the direction. On ACK the transfer opens, status bit 0 (no-acknowledge) clears and pending sets. On NACK status bit 0 sets and no transfer opens.
- R9: A data write while a transfer is open issues a send operation (code 1). On ACK status bit 0 clears and pending sets. On NACK status bit 0 sets, a stop operation follows and the transfer closes.
- R10: A data read returns the last received byte. When master is set, a transfer is open and control bit 4 (transmit) is clear, the read also issues a receive operation (code 2), stores the returned byte and sets pending. Otherwise no operation is issued.
- R11: Registers sit at offsets 0x0 control, 0x2 status, 0x4 data, 0x6 own address and 0x8 divider. Any other offset reads 0x00, and writes to it change nothing. The own address keeps bits 7:1, the divider keeps bits 5:0, and control keeps bits 7:4 and 2.
- R12: An operation stays valid with its code and byte unchanged until the target raises ready. `host_ready` is low while an operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Access accepted when high together with host_sel |
| host_rdata | output | 8 | Read data, valid the cycle after a read is accepted |
| irq | output | 1 | Interrupt line |
| tgt_valid | output | 1 | Target operation pending |
| tgt_op | output | 2 | Operation code: 0 start, 1 send, 2 receive, 3 stop |
| tgt_byte | output | 8 | Address byte or data byte for start and send |
| tgt_ready | input | 1 | Target completes the operation this cycle |
| tgt_ack | input | 1 | 1 = ACK, sampled with tgt_ready |
| tgt_rdata | input | 8 | Received byte, sampled with tgt_ready |

## Verification
A register write is accepted on a rising edge, and its effect on the registers and on `irq` appears right after that edge. A target operation it launches drives `tgt_valid` from that same edge. Read data appears on `host_rdata` one cycle after the accepting edge. The result of an operation (flags, opened or closed transfer, stored byte, `irq`, `host_ready`) appears right after the edge on which valid and ready were both high. A NACKed send is followed at once by a stop that stays valid. The bench model applies each change just after the edge where the design applies it, and compares on the falling edge in between.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
    localparam int BYTE_W = 8;
    localparam int OWN_W  = 7;
    localparam int DIV_W  = 6;
    localparam int NREG   = 5;

    localparam int C_EN = 7;
    localparam int C_IE = 6;
    localparam int C_MS = 5;
    localparam int C_TX = 4;
    localparam int C_RS = 2;
    localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hF4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_STAT = 3'd1,
        RG_DATA = 3'd2,
        RG_OWN  = 3'd3,
        RG_DIV  = 3'd4,
        RG_NONE = 3'd7
    } reg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              iflag;
        logic              arbl;
        logic              busy;
        logic              nak;
        logic [OWN_W-1:0]  own;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] rx;
        logic              open;
        logic              pend;
        op_e               op;
        logic [BYTE_W-1:0] obyte;
    } st_t;

    localparam st_t ST_RST = '0;
endpackage

// File: rtl/i2cbm_decode.sv
module i2cbm_decode
    import i2cbm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_e              rsel
);
    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(2 * i);
        assign hit[i] = (addr == OFS);
    end

    always_comb begin
        rsel = RG_NONE;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rsel = reg_e'(i);
        end
    end
endmodule

// File: rtl/i2cbm_rdmux.sv
module i2cbm_rdmux
    import i2cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_take,
    input  reg_e              rsel,
    input  logic [BYTE_W-1:0] ctrl_v,
    input  logic [BYTE_W-1:0] stat_v,
    input  logic [BYTE_W-1:0] data_v,
    input  logic [BYTE_W-1:0] own_v,
    input  logic [BYTE_W-1:0] div_v,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] rdata_d, rdata_q;
    logic [BYTE_W-1:0] pick;

    always_comb begin
        unique case (rsel)
            RG_CTRL: pick = ctrl_v;
            RG_STAT: pick = stat_v;
            RG_DATA: pick = data_v;
            RG_OWN:  pick = own_v;
            RG_DIV:  pick = div_v;
            default: pick = '0;
        endcase
        rdata_d = rd_take ? pick : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/i2cbm_core.sv
module i2cbm_core
    import i2cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  reg_e              rsel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tgt_ready,
    input  logic              tgt_ack,
    input  logic [BYTE_W-1:0] tgt_rdata,
    output logic              pend,
    output logic              irq,
    output logic              tgt_valid,
    output logic [1:0]        tgt_op,
    output logic [BYTE_W-1:0] tgt_byte,
    output logic [BYTE_W-1:0] ctrl_v,
    output logic [BYTE_W-1:0] stat_v,
    output logic [BYTE_W-1:0] rx_v,
    output logic [BYTE_W-1:0] own_v,
    output logic [BYTE_W-1:0] div_v
);
    st_t  q, d;
    logic open_n;
    logic stop_n;
    logic handshake;

    assign handshake = q.pend && tgt_ready;

    always_comb begin
        d      = q;
        open_n = q.open;
        stop_n = 1'b0;
        if (handshake) begin
            d.pend = 1'b0;
            case (q.op)
                OP_START: begin
                    if (tgt_ack) begin
                        d.open  = 1'b1;
                        d.nak   = 1'b0;
                        d.iflag = 1'b1;
                    end else begin
                        d.nak = 1'b1;
                    end
                end
                OP_SEND: begin
                    if (tgt_ack) begin
                        d.nak   = 1'b0;
                        d.iflag = 1'b1;
                    end else begin
                        d.nak  = 1'b1;
                        d.open = 1'b0;
                        d.pend = 1'b1;
                        d.op   = OP_STOP;
                    end
                end
                OP_RECV: begin
                    d.rx    = tgt_rdata;
                    d.iflag = 1'b1;
                end
                default: ;
            endcase
        end else if (acc && wr) begin
            case (rsel)
                RG_CTRL: begin
                    if (q.ctrl[C_EN] && !wdata[C_EN]) begin
                        d     = ST_RST;
                        d.own = q.own;
                        if (q.open) begin
                            d.pend = 1'b1;
                            d.op   = OP_STOP;
                        end
                    end else begin
                        d.ctrl = wdata & CTRL_KEEP;
                        d.busy = wdata[C_MS];
                        if (!wdata[C_MS] && open_n) begin
                            open_n = 1'b0;
                            stop_n = 1'b1;
                        end
                        if (wdata[C_RS] && open_n) begin
                            open_n       = 1'b0;
                            stop_n       = 1'b1;
                            d.ctrl[C_RS] = 1'b0;
                        end
                        d.open = open_n;
                        if (stop_n) begin
                            d.pend = 1'b1;
                            d.op   = OP_STOP;
                        end
                    end
                end
                RG_STAT: begin
                    if (q.iflag && !wdata[1]) d.iflag = 1'b0;
                    if (q.arbl && !wdata[4])  d.arbl  = 1'b0;
                end
                RG_DATA: begin
                    if (q.ctrl[C_EN] && q.ctrl[C_MS]) begin
                        d.pend  = 1'b1;
                        d.op    = q.open ? OP_SEND : OP_START;
                        d.obyte = wdata;
                    end
                end
                RG_OWN: d.own = wdata[BYTE_W-1:1];
                RG_DIV: d.div = wdata[DIV_W-1:0];
                default: ;
            endcase
        end else if (acc && !wr && rsel == RG_DATA) begin
            if (q.ctrl[C_MS] && q.open && !q.ctrl[C_TX]) begin
                d.pend = 1'b1;
                d.op   = OP_RECV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign pend      = q.pend;
    assign irq       = q.iflag && q.ctrl[C_EN] && q.ctrl[C_IE];
    assign tgt_valid = q.pend;
    assign tgt_op    = q.op;
    assign tgt_byte  = q.obyte;
    assign ctrl_v    = q.ctrl;
    assign stat_v    = {2'b00, q.busy, q.arbl, 2'b00, q.iflag, q.nak};
    assign rx_v      = q.rx;
    assign own_v     = {q.own, 1'b0};
    assign div_v     = {{(BYTE_W-DIV_W){1'b0}}, q.div};

    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_op) && $stable(tgt_byte)); // R12
    AST_RECV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && tgt_op == OP_RECV |-> q.open); // R10
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && tgt_op == OP_START |-> !q.open); // R8
    AST_START_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && tgt_ready && tgt_op == OP_START && tgt_ack |=> q.iflag && q.open); // R8
    AST_SEND_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && tgt_ready && tgt_op == OP_SEND && !tgt_ack |=> tgt_valid && tgt_op == OP_STOP && !q.open); // R9
    AST_SOFTRST_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        acc && wr && rsel == RG_CTRL && q.ctrl[C_EN] && !wdata[C_EN] && !handshake |=> $stable(q.own) && q.ctrl == '0); // R3
endmodule

// File: rtl/i2cbm_top.sv
module i2cbm_top
    import i2cbm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_ready,
    output logic [7:0]        host_rdata,
    output logic              irq,
    output logic              tgt_valid,
    output logic [1:0]        tgt_op,
    output logic [7:0]        tgt_byte,
    input  logic              tgt_ready,
    input  logic              tgt_ack,
    input  logic [7:0]        tgt_rdata
);
    reg_e              rsel;
    logic              pend;
    logic              acc;
    logic [BYTE_W-1:0] ctrl_v, stat_v, rx_v, own_v, div_v;

    assign host_ready = !pend;
    assign acc        = host_sel && !pend;

    i2cbm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (host_addr),
        .rsel (rsel)
    );

    i2cbm_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wr        (host_wr),
        .rsel      (rsel),
        .wdata     (host_wdata),
        .tgt_ready (tgt_ready),
        .tgt_ack   (tgt_ack),
        .tgt_rdata (tgt_rdata),
        .pend      (pend),
        .irq       (irq),
        .tgt_valid (tgt_valid),
        .tgt_op    (tgt_op),
        .tgt_byte  (tgt_byte),
        .ctrl_v    (ctrl_v),
        .stat_v    (stat_v),
        .rx_v      (rx_v),
        .own_v     (own_v),
        .div_v     (div_v)
    );

    i2cbm_rdmux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_take (acc && !host_wr),
        .rsel    (rsel),
        .ctrl_v  (ctrl_v),
        .stat_v  (stat_v),
        .data_v  (rx_v),
        .own_v   (own_v),
        .div_v   (div_v),
        .rdata   (host_rdata)
    );

    AST_HOST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !host_ready); // R12
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_v[C_EN] && ctrl_v[C_IE] && stat_v[1]); // R2
endmodule

// File: tb/i2cbm_top_tb.sv
module i2cbm_top_tb;
    localparam int AW = 4;
    localparam logic [6:0] TGT_ADDR = 7'h52;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_ready, irq, tgt_valid;
    logic [7:0]    host_rdata, tgt_byte;
    logic [1:0]    tgt_op;
    logic          tgt_ready = 1'b0, tgt_ack = 1'b0;
    logic [7:0]    tgt_rdata = '0;

    i2cbm_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .irq(irq), .tgt_valid(tgt_valid), .tgt_op(tgt_op),
        .tgt_byte(tgt_byte), .tgt_ready(tgt_ready), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit live = 0;

    // reference model state
    bit [7:0] m_ctrl = 0, m_own = 0, m_div = 0, m_rx = 0;
    bit m_iflag = 0, m_busy = 0, m_nak = 0, m_open = 0;
    int exp_op[$];
    int exp_byte[$];
    int lat = 0, wcnt = 0;
    int rcount = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] m_stat();
        return {2'b00, m_busy, 1'b0, 2'b00, m_iflag, m_nak};
    endfunction

    function automatic void push_op(int op, int b);
        exp_op.push_back(op);
        exp_byte.push_back(b);
    endfunction

    function automatic void m_write(int a, bit [7:0] v);
        case (a)
            0: begin
                if (m_ctrl[7] && !v[7]) begin
                    if (m_open) push_op(3, -1);
                    m_open = 0; m_ctrl = 0; m_iflag = 0; m_busy = 0;
                    m_nak = 0; m_div = 0; m_rx = 0;
                end else begin
                    m_ctrl = v & 8'hF4;
                    m_busy = v[5];
                    if (!v[5] && m_open) begin m_open = 0; push_op(3, -1); end
                    if (v[2] && m_open) begin m_open = 0; m_ctrl[2] = 0; push_op(3, -1); end
                end
            end
            2: if (m_iflag && !v[1]) m_iflag = 0;
            4: if (m_ctrl[7] && m_ctrl[5]) push_op(m_open ? 1 : 0, v);
            6: m_own = v & 8'hFE;
            8: m_div = v & 8'h3F;
            default: ;
        endcase
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_ctrl;
            2: return m_stat();
            4: return m_rx;
            6: return m_own;
            8: return m_div;
            default: return 0;
        endcase
    endfunction

    task automatic wait_idle();
        while (exp_op.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int a, bit [7:0] v);
        while (!host_ready) @(negedge clk);
        host_sel = 1; host_wr = 1; host_addr = AW'(a); host_wdata = v;
        @(posedge clk); #1;
        host_sel = 0; host_wr = 0;
        m_write(a, v);
        wait_idle();
    endtask

    task automatic rd(string tag, int a);
        int e;
        while (!host_ready) @(negedge clk);
        host_sel = 1; host_wr = 0; host_addr = AW'(a);
        e = m_read(a);
        @(posedge clk); #1;
        host_sel = 0;
        if (a == 4 && m_ctrl[5] && m_open && !m_ctrl[4]) push_op(2, -1);
        @(negedge clk);
        chk(tag, host_rdata, e);
        wait_idle();
    endtask

    // behavioural target: raise ready after a varying wait
    always @(negedge clk) begin
        if (tgt_ready) tgt_ready = 0;
        else if (rst_n && tgt_valid) begin
            if (wcnt >= lat) begin
                tgt_ready = 1;
                wcnt = 0;
                lat = (lat + 1) % 3;
                case (tgt_op)
                    2'd0: tgt_ack = (tgt_byte[7:1] == TGT_ADDR);
                    2'd1: tgt_ack = (tgt_byte != 8'hFF);
                    2'd2: begin tgt_ack = 1; tgt_rdata = 8'hA0 + 8'(rcount); rcount++; end
                    default: tgt_ack = 1;
                endcase
            end else wcnt++;
        end
    end

    // apply each completed operation to the model just after the edge
    always @(posedge clk) begin
        if (rst_n && tgt_valid && tgt_ready) begin
            int op, b;
            op = tgt_op; b = tgt_byte;
            #1;
            if (exp_op.size() == 0) chk("R12 unexpected op", op, 99);
            else begin
                int eo, eb;
                eo = exp_op.pop_front(); eb = exp_byte.pop_front();
                chk("R12 op code", op, eo);
                if (eb >= 0) chk("R8/R9 op byte", b, eb);
                case (op)
                    0: if (tgt_ack) begin m_open = 1; m_nak = 0; m_iflag = 1; end
                       else m_nak = 1;
                    1: if (tgt_ack) begin m_nak = 0; m_iflag = 1; end
                       else begin m_nak = 1; m_open = 0; push_op(3, -1); end
                    2: begin m_rx = tgt_rdata; m_iflag = 1; end
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (live) begin
            chk("R2 irq level", irq, m_iflag && m_ctrl[7] && m_ctrl[6]);
            chk("R12 host_ready", host_ready, exp_op.size() == 0);
            chk("R7 tgt_valid", tgt_valid, exp_op.size() != 0);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1; live = 1;
        @(negedge clk);
        // R1 reset state
        rd("R1 ctrl", 0); rd("R1 status", 2); rd("R1 data", 4);
        rd("R1 own", 6); rd("R1 div", 8);
        // R11 masks and unmapped offsets
        wr(6, 8'hFF); rd("R11 own mask", 6);
        wr(8, 8'hFF); rd("R11 div mask", 8);
        wr(10, 8'h55); rd("R11 unmapped read", 10);
        wr(3, 8'hFF); rd("R11 odd offset write", 2); rd("R11 odd read", 1);
        rd("R11 div after unmapped", 8);
        // R7 data writes ignored
        wr(4, 8'hA4);
        wr(0, 8'h80); wr(4, 8'hA4);
        rd("R7 status unchanged", 2);
        // R4 busy
        wr(0, 8'hF8); rd("R11 ctrl mask", 0);
        wr(0, 8'hE0); rd("R4 busy set", 2);
        // R8 nack then ack
        wr(4, 8'h22); rd("R8 nack status", 2);
        wr(4, {TGT_ADDR, 1'b0}); rd("R8 ack status", 2);
        // R6 write-zero-to-clear
        wr(2, 8'hFF); rd("R6 write one keeps", 2);
        wr(2, 8'h00); rd("R6 write zero clears", 2);
        // R9 send ack and nack
        wr(4, 8'h3C); rd("R9 send ack", 2);
        wr(2, 8'h00);
        wr(4, 8'hFF); rd("R9 send nack", 2);
        wr(4, {TGT_ADDR, 1'b1}); rd("R8 reopen", 2);
        // R10 receive
        rd("R10 first read old byte", 4);
        rd("R10 second read fetched", 4);
        rd("R10 pending after fetch", 2);
        wr(0, 8'hF0); rd("R10 tx set no fetch", 4); rd("R10 byte kept", 4);
        // R2 gating by interrupt enable
        wr(0, 8'hA0); rd("R2 ctrl ie clear", 0);
        wr(0, 8'hE0);
        // R5 repeated start
        wr(0, 8'hE4); rd("R5 restart self clears", 0);
        wr(4, 8'h11); // next data write is a start, NACKed
        wr(0, 8'hE4); rd("R5 restart kept idle", 0);
        // R4 leave master
        wr(0, 8'hE0); wr(4, {TGT_ADDR, 1'b0});
        wr(0, 8'hC0); rd("R4 busy cleared", 2);
        rd("R10 no fetch when not master", 4);
        // R3 soft reset
        wr(0, 8'hE0); wr(4, {TGT_ADDR, 1'b1}); rd("R10 fetch again", 4);
        wr(8, 8'h15);
        wr(0, 8'h00);
        rd("R3 ctrl", 0); rd("R3 status", 2); rd("R3 data", 4);
        rd("R3 own kept", 6); rd("R3 div", 8);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule